// File: doc/BRIEF.md
# Fault-Injectable Scan Flip-Flop

This block is a one-bit storage cell that behaves as a rising-edge D flip-flop with an asynchronous active-low reset and a complementary output. A 4-bit fault-select code can switch it into one of twelve defect behaviours. The defects are stuck values on the data input, the true output, the complement output, the clock and the reset, delayed rising or falling transitions on the true output, and a wired-AND short between the two outputs. A multiplexed scan path lets a test controller load a chosen state, run a capture cycle and unload the result through `scan_out`.

A defect-free shadow copy of the cell runs beside the faulty one and sees the same stimulus. A registered divergence flag is raised when the faulty outputs differ from the shadow on an edge where the cell is being observed through its scan path. The flag shows when a pattern has detected the injected defect. The fault code is taken only while reset is held, so a defect stays fixed for the whole pattern. Timing defects are modelled as one cycle of lag, not as analog delay.

Top module: `fault_inject_ff`

## Requirements
- R1: With fault code 0 and `scan_en` low, `q` takes the value of `d` at each rising clock edge, `qn` is always the complement of `q`, and `scan_out` equals `q`.
- R2: With `scan_en` high, the cell captures `scan_in` instead of `d`, and the shadow copy does the same.
- R3: Driving `rst_n` low forces `q` to 0, `qn` to 1 and `diverge` to 0 at once, without waiting for a clock edge (except under code 9). While `rst_n` is low, `fault_sel` is copied into the active fault mode on every clock edge.
- R4: Code 1 (data stuck-at-0) and code 2 (data stuck-at-1) make functional captures store 0 or 1, whatever value is driven on `d`. Scan captures from `scan_in` are not affected.
- R5: Code 3 forces `q` to 0 and code 4 forces `q` to 1, and `scan_out` follows the forced `q`. Code 5 forces `qn` to 0 and code 6 forces `qn` to 1. In all four modes the other output still reflects the stored state.
- R6: Code 7 (clock stuck) stops all captures after reset, so `q` keeps the value it held when reset was released.
- R7: Code 8 (reset stuck-at-0) keeps `q` at 0 permanently. Code 9 (reset stuck-at-1) makes a low `rst_n` have no effect on the stored state, which keeps capturing on every edge.
- R8: Code 10 (slow-to-rise) makes a 0-to-1 change of the stored state reach `q` one cycle late. Code 11 (slow-to-fall) does the same for a 1-to-0 change. The opposite transition appears without delay.
- R9: Code 12 (output short) makes `q` and `qn` both resolve to the wired-AND of their values, which is 0 on every cycle.
- R10: Codes 13, 14 and 15 behave exactly like code 0.
- R11: `diverge` is 1 for the cycle after a rising edge if, just before that edge, `scan_en` was high and the faulty `q` or `qn` differed from the shadow's. Otherwise it is 0.
- R12: Changes on `fault_sel` while `rst_n` is high have no effect on the cell's behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the window in which the fault code is taken |
| d | input | 1 | Functional data input |
| scan_en | input | 1 | Selects `scan_in` as the capture source and marks an observation edge |
| scan_in | input | 1 | Serial scan data input |
| fault_sel | input | 4 | Defect code, 0 = none, 1..12 = defects, 13..15 = none |
| q | output | 1 | True output, after defect injection |
| qn | output | 1 | Complement output, after defect injection |
| scan_out | output | 1 | Scan output, taken from the possibly faulty `q` |
| diverge | output | 1 | Registered flag: faulty and shadow outputs differed on an observed edge |

## Verification
The assertions check on every cycle the properties that hold for a mode as a whole. In the fault-free mode, each edge captures `d` or `scan_in` and the two outputs stay complementary. Under a clock stuck mode `q` never moves, and under a reset-stuck-at-0 mode or an output short the outputs take their fixed values. The divergence flag never rises without a preceding observation edge, and the fault mode never changes outside reset. Only the bench scenarios can show the ordered behaviours. These are the one-cycle lag of a slow transition after a launch and capture pair, and a reset pulse that a stuck-at-1 reset ignores. They also include a data-pin stuck value that is invisible to functional loads yet leaves scan loads intact, and a stuck output that raises the flag only once it is shifted out rather than captured functionally.

// File: rtl/fiff_pkg.sv
// Package: shared fault-mode encoding and the decoded control bundle for
// the fault-injectable flip-flop. Assumes a 4-bit code space where every
// value not named below means "no defect".
package fiff_pkg;

    localparam int FSEL_W = 4;

    typedef enum logic [FSEL_W-1:0] {
        FLT_NONE     = 4'd0,
        FLT_D_SA0    = 4'd1,
        FLT_D_SA1    = 4'd2,
        FLT_Q_SA0    = 4'd3,
        FLT_Q_SA1    = 4'd4,
        FLT_QN_SA0   = 4'd5,
        FLT_QN_SA1   = 4'd6,
        FLT_CLK_HOLD = 4'd7,
        FLT_RST_SA0  = 4'd8,
        FLT_RST_SA1  = 4'd9,
        FLT_Q_SLOWR  = 4'd10,
        FLT_Q_SLOWF  = 4'd11,
        FLT_BRIDGE   = 4'd12,
        FLT_SPARE13  = 4'd13,
        FLT_SPARE14  = 4'd14,
        FLT_SPARE15  = 4'd15
    } fault_e;

    typedef struct packed {
        logic d_force;   // data pin tied
        logic d_val;
        logic q_force;   // true output tied
        logic q_val;
        logic qn_force;  // complement output tied
        logic qn_val;
        logic hold;      // no capture ever happens
        logic rst_force; // reset net tied
        logic rst_val;
        logic rise_lag;  // 0->1 change seen one cycle late
        logic fall_lag;  // 1->0 change seen one cycle late
        logic bridge;    // q and qn shorted, wired-AND
    } fault_ctrl_t;

    // Turns a fault mode into individual control strobes.
    function automatic fault_ctrl_t decode_mode(input fault_e m);
        fault_ctrl_t c;
        c = '0;
        case (m)
            FLT_D_SA0:    begin c.d_force = 1'b1;   c.d_val = 1'b0;   end
            FLT_D_SA1:    begin c.d_force = 1'b1;   c.d_val = 1'b1;   end
            FLT_Q_SA0:    begin c.q_force = 1'b1;   c.q_val = 1'b0;   end
            FLT_Q_SA1:    begin c.q_force = 1'b1;   c.q_val = 1'b1;   end
            FLT_QN_SA0:   begin c.qn_force = 1'b1;  c.qn_val = 1'b0;  end
            FLT_QN_SA1:   begin c.qn_force = 1'b1;  c.qn_val = 1'b1;  end
            FLT_CLK_HOLD: c.hold = 1'b1;
            FLT_RST_SA0:  begin c.rst_force = 1'b1; c.rst_val = 1'b0; end
            FLT_RST_SA1:  begin c.rst_force = 1'b1; c.rst_val = 1'b1; end
            FLT_Q_SLOWR:  c.rise_lag = 1'b1;
            FLT_Q_SLOWF:  c.fall_lag = 1'b1;
            FLT_BRIDGE:   c.bridge = 1'b1;
            default:      c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fiff_mode_reg.sv
// Module: fault mode register. Copies the requested fault code while the
// real reset is held and keeps it frozen once reset is released.
// Assumes rst_n is the true (never faulted) reset of the test harness.
module fiff_mode_reg
    import fiff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FSEL_W-1:0] fault_sel,
    output fault_e            mode
);

    fault_e mode_r;

    // Load the code on reset entry and on each edge during reset; hold after.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_r <= fault_e'(fault_sel);
        else        mode_r <= mode_r;
    end

    assign mode = mode_r;

endmodule

// File: rtl/fiff_store.sv
// Module: one-bit storage element with asynchronous active-low reset and a
// capture enable. Used for both the faulty cell and the defect-free shadow.
// Assumes the enable is a level that models presence or absence of the clock.
module fiff_store #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic cap_en,
    input  logic din,
    output logic dout
);

    logic state_r;

    // Capture din on each enabled rising edge; clear on reset.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)     state_r <= RST_VAL;
        else if (cap_en) state_r <= din;
    end

    assign dout = state_r;

endmodule

// File: rtl/fiff_pin_fault.sv
// Module: output-side defect stage. Applies the one-cycle transition lag,
// output stuck values and the q/qn wired-AND short to the stored state.
// Assumes its history register shares clock, reset and enable with the
// faulty store so the lag refers to the store's previous value.
module fiff_pin_fault
    import fiff_pkg::*;
(
    input  logic        clk,
    input  logic        arst_n,
    input  logic        cap_en,
    input  logic        state,
    input  fault_ctrl_t ctrl,
    output logic        q_pin,
    output logic        qn_pin
);

    logic hist_r;
    logic q_lag;
    logic qn_int;

    // Remember the stored state of the previous cycle for the lag model.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)     hist_r <= 1'b0;
        else if (cap_en) hist_r <= state;
    end

    // Slow rise needs two cycles at 1; slow fall needs two cycles at 0.
    always_comb begin
        if (ctrl.rise_lag)      q_lag = state & hist_r;
        else if (ctrl.fall_lag) q_lag = state | hist_r;
        else                    q_lag = state;
    end

    assign qn_int = ~q_lag;

    // Resolve the true output: short, tie or pass-through.
    always_comb begin
        if (ctrl.bridge)       q_pin = q_lag & qn_int;
        else if (ctrl.q_force) q_pin = ctrl.q_val;
        else                   q_pin = q_lag;
    end

    // Resolve the complement output: short, tie or pass-through.
    always_comb begin
        if (ctrl.bridge)        qn_pin = q_lag & qn_int;
        else if (ctrl.qn_force) qn_pin = ctrl.qn_val;
        else                    qn_pin = qn_int;
    end

endmodule

// File: rtl/fiff_compare.sv
// Module: divergence flag. Registers whether the faulty outputs differed
// from the shadow outputs on an edge where the scan path was observing.
// Assumes rst_n is the true reset, so the flag clears regardless of mode.
module fiff_compare (
    input  logic clk,
    input  logic rst_n,
    input  logic observe,
    input  logic q_bad,
    input  logic qn_bad,
    input  logic q_good,
    input  logic qn_good,
    output logic flag
);

    logic flag_r;
    logic differ;

    assign differ = (q_bad != q_good) | (qn_bad != qn_good);

    // One-cycle pulse after each observed edge with differing outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_r <= 1'b0;
        else        flag_r <= observe & differ;
    end

    assign flag = flag_r;

endmodule

// File: rtl/fault_inject_ff.sv
// Module: fault-injectable scan flip-flop. A faulty cell and a defect-free
// shadow share the stimulus; a registered flag reports divergence seen
// through the scan path. Assumes fault_sel is set up before reset is
// released and rst_n is driven glitch-free by the test harness.
module fault_inject_ff
    import fiff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d,
    input  logic              scan_en,
    input  logic              scan_in,
    input  logic [FSEL_W-1:0] fault_sel,
    output logic              q,
    output logic              qn,
    output logic              scan_out,
    output logic              diverge
);

    fault_e      mode_r;
    fault_ctrl_t ctrl;
    logic        d_pin;
    logic        din_bad;
    logic        din_good;
    logic        rst_eff_n;
    logic        cap_bad;
    logic        state_bad;
    logic        state_good;
    logic        q_bad;
    logic        qn_bad;

    fiff_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_sel (fault_sel),
        .mode      (mode_r)
    );

    assign ctrl = decode_mode(mode_r);

    // Data pin defect sits ahead of the scan multiplexer.
    assign d_pin     = ctrl.d_force ? ctrl.d_val : d;
    assign din_bad   = scan_en ? scan_in : d_pin;
    assign din_good  = scan_en ? scan_in : d;
    assign rst_eff_n = ctrl.rst_force ? ctrl.rst_val : rst_n;
    assign cap_bad   = ~ctrl.hold;

    fiff_store #(.RST_VAL(1'b0)) u_bad (
        .clk    (clk),
        .arst_n (rst_eff_n),
        .cap_en (cap_bad),
        .din    (din_bad),
        .dout   (state_bad)
    );

    fiff_store #(.RST_VAL(1'b0)) u_good (
        .clk    (clk),
        .arst_n (rst_n),
        .cap_en (1'b1),
        .din    (din_good),
        .dout   (state_good)
    );

    fiff_pin_fault u_pins (
        .clk    (clk),
        .arst_n (rst_eff_n),
        .cap_en (cap_bad),
        .state  (state_bad),
        .ctrl   (ctrl),
        .q_pin  (q_bad),
        .qn_pin (qn_bad)
    );

    fiff_compare u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .observe (scan_en),
        .q_bad   (q_bad),
        .qn_bad  (qn_bad),
        .q_good  (state_good),
        .qn_good (~state_good),
        .flag    (diverge)
    );

    assign q        = q_bad;
    assign qn       = qn_bad;
    assign scan_out = q_bad;

endmodule

// File: rtl/fiff_checker.sv
// Module: property checker for fault_inject_ff, attached by bind. Watches
// ports and the active fault mode.
module fiff_checker
    import fiff_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   d,
    input logic   scan_en,
    input logic   scan_in,
    input logic   q,
    input logic   qn,
    input logic   diverge,
    input fault_e mode
);

    // R1
    func_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FLT_NONE && $past(rst_n) && !$past(scan_en)) |-> (q == $past(d)));

    // R1
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FLT_NONE) |-> (qn == !q));

    // R2
    scan_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FLT_NONE && $past(rst_n) && $past(scan_en)) |-> (q == $past(scan_in)));

    // R4
    d_tied_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FLT_D_SA1 && $past(rst_n) && !$past(scan_en)) |-> q);

    // R6
    clock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FLT_CLK_HOLD && $past(rst_n)) |-> $stable(q));

    // R7
    reset_tied_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FLT_RST_SA0) |-> (!q && qn));

    // R9
    short_wired_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FLT_BRIDGE) |-> (!q && !qn));

    // R11
    flag_needs_observe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (diverge && $past(rst_n)) |-> $past(scan_en));

    // R12
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode));

endmodule

bind fault_inject_ff fiff_checker u_fiff_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .d       (d),
    .scan_en (scan_en),
    .scan_in (scan_in),
    .q       (q),
    .qn      (qn),
    .diverge (diverge),
    .mode    (mode_r)
);

// File: tb/tb_fault_inject_ff.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the faulty cell, the shadow and the
// flag, compared at every falling edge, plus directed corner-case checks.
module tb_fault_inject_ff;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       d = 1'b0;
    logic       scan_en = 1'b0;
    logic       scan_in = 1'b0;
    logic [3:0] fault_sel = 4'd0;
    logic       q, qn, scan_out, diverge;

    int vectors = 0;
    int misses  = 0;

    // reference model state
    int m_code = 0;
    int m_fq = 0, m_fp = 0, m_gq = 0, m_flag = 0;
    logic [15:0] lfsr = 16'hACE1;

    fault_inject_ff dut (
        .clk(clk), .rst_n(rst_n), .d(d), .scan_en(scan_en),
        .scan_in(scan_in), .fault_sel(fault_sel),
        .q(q), .qn(qn), .scan_out(scan_out), .diverge(diverge)
    );

    always #2.5 clk = ~clk;

    function automatic int m_qobs();
        if (m_code == 10) return m_fq & m_fp;
        if (m_code == 11) return m_fq | m_fp;
        return m_fq;
    endfunction

    function automatic int m_q();
        if (m_code == 3 || m_code == 12) return 0;
        if (m_code == 4) return 1;
        return m_qobs();
    endfunction

    function automatic int m_qn();
        if (m_code == 5 || m_code == 12) return 0;
        if (m_code == 6) return 1;
        return 1 - m_qobs();
    endfunction

    function automatic string req_of(int c);
        case (c)
            0:       return "R1";
            1, 2:    return "R4";
            3, 4, 5, 6: return "R5";
            7:       return "R6";
            8, 9:    return "R7";
            10, 11:  return "R8";
            12:      return "R9";
            default: return "R10";
        endcase
    endfunction

    // Model update for one rising edge, using the inputs held across it.
    task automatic model_edge();
        int nd;
        if (rst_n) begin
            m_flag = (scan_en && (m_q() != m_gq || m_qn() != 1 - m_gq)) ? 1 : 0;
            m_gq = scan_en ? int'(scan_in) : int'(d);
            if (m_code == 8) begin
                m_fq = 0; m_fp = 0;
            end else if (m_code != 7) begin
                nd = (m_code == 1) ? 0 : (m_code == 2) ? 1 : int'(d);
                m_fp = m_fq;
                m_fq = scan_en ? int'(scan_in) : nd;
            end
        end else begin
            m_flag = 0; m_gq = 0; m_code = int'(fault_sel);
            if (m_code == 9) begin
                m_fp = m_fq; m_fq = scan_en ? int'(scan_in) : int'(d);
            end else begin
                m_fq = 0; m_fp = 0;
            end
        end
    endtask

    task automatic check_bit(string tag, string what, logic act, int exp);
        vectors++;
        if (int'(act) != exp) begin
            misses++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Full comparison of every output against the model.
    task automatic check_all(string tag);
        vectors++;
        if (int'(q) != m_q() || int'(qn) != m_qn() || int'(scan_out) != m_q()
            || int'(diverge) != m_flag) begin
            misses++;
            $display("FAIL %s code %0d: actual q=%0d qn=%0d so=%0d dv=%0d expected q=%0d qn=%0d so=%0d dv=%0d",
                     tag, m_code, q, qn, scan_out, diverge, m_q(), m_qn(), m_q(), m_flag);
        end
    endtask

    // Drive at the falling edge, update the model at the rising edge,
    // compare at the next falling edge.
    task automatic cycle(logic dv, logic sev, logic siv, string tag);
        d = dv; scan_en = sev; scan_in = siv;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset(int code);
        int old;
        fault_sel = 4'(code); d = 1'b0; scan_en = 1'b0; scan_in = 1'b0;
        rst_n = 1'b0;
        old = m_code; m_code = code; m_flag = 0; m_gq = 0;
        if (!(old == 9 && code == 9)) begin m_fq = 0; m_fp = 0; end
        repeat (3) begin
            @(posedge clk); model_edge();
            @(negedge clk);
        end
        rst_n = 1'b1;
        #0.5;
    endtask

    task automatic random_run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[0], lfsr[3] & lfsr[5], lfsr[7], tag);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        misses++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        @(negedge clk);
        do_reset(0);
        // R3: reset state
        check_bit("R3", "q after reset", q, 0);
        check_bit("R3", "qn after reset", qn, 1);
        check_bit("R3", "diverge after reset", diverge, 0);

        // R1: functional capture
        cycle(1, 0, 0, "R1"); check_bit("R1", "q took d=1", q, 1);
        cycle(0, 0, 1, "R1"); check_bit("R1", "q took d=0", q, 0);
        // R2: scan capture overrides d
        cycle(0, 1, 1, "R2"); check_bit("R2", "q took scan_in=1", scan_out, 1);
        cycle(1, 1, 0, "R2"); check_bit("R2", "q took scan_in=0", q, 0);
        // R12: fault code change outside reset is ignored
        fault_sel = 4'd3;
        cycle(1, 0, 0, "R12"); check_bit("R12", "q still follows d", q, 1);
        random_run(20, "R12");
        // R3: asynchronous reset mid-cycle
        @(posedge clk); model_edge();
        #1.0; fault_sel = 4'd0; rst_n = 1'b0;
        m_code = 0; m_fq = 0; m_fp = 0; m_gq = 0; m_flag = 0;
        #0.5;
        check_bit("R3", "q cleared without edge", q, 0);
        @(negedge clk);

        // R4: data stuck-at-0 ignores d, scan still loads
        do_reset(1);
        cycle(1, 0, 0, "R4"); check_bit("R4", "d SA0 q", q, 0);
        cycle(1, 1, 1, "R4"); check_bit("R4", "scan load under d SA0", q, 1);
        do_reset(2);
        cycle(0, 0, 0, "R4"); check_bit("R4", "d SA1 q", q, 1);

        // R11 with R5: q stuck-at-0 detected only on scan observation
        do_reset(3);
        cycle(1, 0, 0, "R5"); check_bit("R5", "q SA0 q", q, 0);
        check_bit("R5", "q SA0 qn tracks state", qn, 0);
        cycle(1, 0, 0, "R11"); check_bit("R11", "no flag without scan", diverge, 0);
        cycle(0, 1, 0, "R11"); check_bit("R11", "flag after observed edge", diverge, 1);
        cycle(0, 1, 0, "R11"); check_bit("R11", "flag drops when equal", diverge, 0);
        do_reset(5);
        cycle(0, 0, 0, "R5"); check_bit("R5", "qn SA0 qn", qn, 0);
        check_bit("R5", "qn SA0 q", q, 0);

        // R6: clock stuck holds q
        do_reset(7);
        cycle(1, 0, 0, "R6"); check_bit("R6", "no capture", q, 0);
        cycle(1, 1, 1, "R6"); check_bit("R6", "no scan capture", q, 0);

        // R7: reset stuck-at-0 and stuck-at-1
        do_reset(8);
        cycle(1, 0, 0, "R7"); check_bit("R7", "reset SA0 q", q, 0);
        do_reset(9);
        cycle(1, 0, 0, "R7"); check_bit("R7", "reset SA1 loads", q, 1);
        #1.0; rst_n = 1'b0; m_flag = 0; m_gq = 0;
        #0.5;
        check_bit("R7", "reset ignored", q, 1);
        @(negedge clk);
        d = 1'b1;
        @(posedge clk); model_edge(); @(negedge clk);
        check_bit("R7", "captures during reset", q, 1);
        rst_n = 1'b1; #0.5;

        // R8: launch then capture exposes the lag
        do_reset(10);
        cycle(1, 0, 0, "R8"); check_bit("R8", "slow rise hidden", q, 0);
        cycle(1, 0, 0, "R8"); check_bit("R8", "slow rise late", q, 1);
        cycle(0, 0, 0, "R8"); check_bit("R8", "fall on time", q, 0);
        do_reset(11);
        cycle(1, 0, 0, "R8"); check_bit("R8", "rise on time", q, 1);
        cycle(0, 0, 0, "R8"); check_bit("R8", "slow fall hidden", q, 1);
        cycle(0, 0, 0, "R8"); check_bit("R8", "slow fall late", q, 0);

        // R9: output short
        do_reset(12);
        cycle(1, 0, 0, "R9"); check_bit("R9", "short q", q, 0);
        check_bit("R9", "short qn", qn, 0);

        // R10: spare code
        do_reset(14);
        cycle(1, 0, 0, "R10"); check_bit("R10", "spare code q", q, 1);

        // every code under pseudo-random stimulus
        for (int c = 0; c < 16; c++) begin
            do_reset(c);
            random_run(40, req_of(c));
        end
        report();
    end

endmodule